// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore with Cross-Core Interrupts

This block gives two processors a small bank of hardware semaphores and a doorbell path between them. Each processor has its own register-access target port. A processor claims a semaphore by reading that semaphore's register, and the read returns whether the claim succeeded. The owner releases the semaphore by writing zero to the same register. Every claim or release that succeeds is reported to the other processor through an interrupt status bit. That bit is gated by an enable bit and drives a level interrupt request. A producer can therefore fill a shared buffer while it owns a semaphore, then release it, and the consumer wakes on the interrupt without polling.

Each semaphore is a three-state machine (`sem_state_t`). In `SEM_FREE` the owner field is empty. A claim read from port 0 takes the transition FREE→HELD0. If port 0 does not claim and port 1 does, the transition is FREE→HELD1. In `SEM_HELD0` only a zero write from port 0 takes HELD0→FREE. In `SEM_HELD1` only a zero write from port 1 takes HELD1→FREE. Every other access leaves the state where it is. Each port has one status/enable pair, in which bit k belongs to semaphore k. The request output of a port is the OR of its status bits ANDed with its enable bits.

Top module: `sem_irq_ctl`

## Requirements
- R1: After reset, every semaphore is free, both status registers and both enable registers are zero, both request outputs are low and both read-data outputs are zero.
- R2: A read of byte offset 4*k (k below NUM_SEM) is a claim of semaphore k. Read data appears on the cycle after the access. It is 1 in bit 0 if the semaphore was free, and that port becomes the owner. It is 0 if the semaphore was held, including by the reader, and the state does not change. Bits above bit 0 are always 0.
- R3: The owner releases semaphore k by writing a value with bit 0 = 0 to offset 4*k. A write from the non-owner, or a write with bit 0 = 1, has no effect.
- R4: If both ports read the same free semaphore in the same cycle, port 0 gets 1 and becomes the owner, and port 1 gets 0. If the owner releases in the same cycle that the other port reads, the read returns 0.
- R5: A successful claim or release of semaphore k by one port sets bit k of the other port's status register. A failed claim or an ignored write sets nothing.
- R6: intreqN is high exactly when a status bit of port N and the matching enable bit are both 1. It follows the registers on the edge that updates them.
- R7: The status register at offset 0x10 is write-one-to-clear. Zero bits in the write data leave their bits unchanged, and a set in the same cycle wins over a clear. A read of 0x10 returns the status in bits NUM_SEM-1:0.
- R8: The enable register at offset 0x14 is written directly from bits NUM_SEM-1:0 of the write data and reads back in those bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel0 | input | 1 | Port 0 access strobe, one cycle per access |
| wr0 | input | 1 | Port 0 write (1) or read (0) |
| addr0 | input | ADDR_W | Port 0 byte offset |
| wdata0 | input | DATA_W | Port 0 write data |
| rdata0 | output | DATA_W | Port 0 read data, registered |
| sel1 | input | 1 | Port 1 access strobe |
| wr1 | input | 1 | Port 1 write (1) or read (0) |
| addr1 | input | ADDR_W | Port 1 byte offset |
| wdata1 | input | DATA_W | Port 1 write data |
| rdata1 | output | DATA_W | Port 1 read data, registered |
| intreq0 | output | 1 | Level interrupt request to processor 0 |
| intreq1 | output | 1 | Level interrupt request to processor 1 |

## Verification
The assertions assume that each access is a single-cycle strobe at a word-aligned offset. They also assume that a request can only rise through an action of the opposite port or a write to the port's own enable register. The bench drives every access as a one-cycle pulse from the falling edge and samples one time step after the rising edge. It uses only the mapped offsets. Concurrent traffic is limited to the same-cycle claim race, so the request-hold and claim-result properties always see the bus patterns they were written for.

// File: rtl/sem_irq_pkg.sv
package sem_irq_pkg;
    typedef enum logic [1:0] {
        SEM_FREE  = 2'd0,
        SEM_HELD0 = 2'd1,
        SEM_HELD1 = 2'd2
    } sem_state_t;

    // word indices (byte offset / 4) of the per-port control registers
    localparam int STATUS_WORD = 4;
    localparam int ENABLE_WORD = 5;
endpackage

// File: rtl/sem_cell.sv
module sem_cell
    import sem_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic claim0,
    input  logic claim1,
    input  logic rel0,
    input  logic rel1,
    output logic grant0,
    output logic grant1,
    output logic freed0,
    output logic freed1
);
    sem_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEM_FREE;
        else        state_q <= state_d;
    end

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEM_FREE: begin
                if (claim0)      state_d = SEM_HELD0;
                else if (claim1) state_d = SEM_HELD1;
            end
            SEM_HELD0: if (rel0) state_d = SEM_FREE;
            SEM_HELD1: if (rel1) state_d = SEM_FREE;
            default:             state_d = SEM_FREE;
        endcase
    end

    // output process: claim results and release events
    always_comb begin
        grant0 = 1'b0;
        grant1 = 1'b0;
        freed0 = 1'b0;
        freed1 = 1'b0;
        unique case (state_q)
            SEM_FREE: begin
                grant0 = claim0;
                grant1 = claim1 && !claim0;
            end
            SEM_HELD0: freed0 = rel0;
            SEM_HELD1: freed1 = rel1;
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
    parameter int NUM_SEM = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SEM-1:0] set_i,
    input  logic               clr_we,
    input  logic [NUM_SEM-1:0] clr_mask,
    input  logic               en_we,
    input  logic [NUM_SEM-1:0] en_val,
    output logic [NUM_SEM-1:0] status_o,
    output logic [NUM_SEM-1:0] enable_o,
    output logic               irq_o
);
    logic [NUM_SEM-1:0] status_q, enable_q, clr_eff;

    assign clr_eff = clr_we ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            enable_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_eff) | set_i;
            if (en_we) enable_q <= en_val;
        end
    end

    assign status_o = status_q;
    assign enable_o = enable_q;
    assign irq_o    = |(status_q & enable_q);
endmodule

// File: rtl/sem_irq_ctl.sv
module sem_irq_ctl
    import sem_irq_pkg::*;
#(
    parameter int NUM_SEM = 3,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel0,
    input  logic              wr0,
    input  logic [ADDR_W-1:0] addr0,
    input  logic [DATA_W-1:0] wdata0,
    output logic [DATA_W-1:0] rdata0,
    input  logic              sel1,
    input  logic              wr1,
    input  logic [ADDR_W-1:0] addr1,
    input  logic [DATA_W-1:0] wdata1,
    output logic [DATA_W-1:0] rdata1,
    output logic              intreq0,
    output logic              intreq1
);
    localparam int NPORT  = 2;
    localparam int WORD_W = ADDR_W - 2;

    logic              sel_v   [NPORT];
    logic              wr_v    [NPORT];
    logic [WORD_W-1:0] word_v  [NPORT];
    logic [DATA_W-1:0] wdat_v  [NPORT];
    logic [DATA_W-1:0] rd_val  [NPORT];
    logic [DATA_W-1:0] rdata_q [NPORT];
    logic              irq_v   [NPORT];

    logic [NUM_SEM-1:0] claim_v  [NPORT];
    logic [NUM_SEM-1:0] rel_v    [NPORT];
    logic [NUM_SEM-1:0] grant_v  [NPORT];
    logic [NUM_SEM-1:0] freed_v  [NPORT];
    logic [NUM_SEM-1:0] status_v [NPORT];
    logic [NUM_SEM-1:0] enable_v [NPORT];

    assign sel_v[0]  = sel0;
    assign wr_v[0]   = wr0;
    assign word_v[0] = addr0[ADDR_W-1:2];
    assign wdat_v[0] = wdata0;
    assign sel_v[1]  = sel1;
    assign wr_v[1]   = wr1;
    assign word_v[1] = addr1[ADDR_W-1:2];
    assign wdat_v[1] = wdata1;

    genvar p, k;
    generate
        for (p = 0; p < NPORT; p++) begin : g_port
            for (k = 0; k < NUM_SEM; k++) begin : g_dec
                assign claim_v[p][k] = sel_v[p] && !wr_v[p] && (word_v[p] == WORD_W'(k));
                assign rel_v[p][k]   = sel_v[p] && wr_v[p] && (word_v[p] == WORD_W'(k))
                                       && !wdat_v[p][0];
            end

            irq_bank #(.NUM_SEM(NUM_SEM)) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .set_i    (grant_v[1-p] | freed_v[1-p]),
                .clr_we   (sel_v[p] && wr_v[p] && (word_v[p] == WORD_W'(STATUS_WORD))),
                .clr_mask (wdat_v[p][NUM_SEM-1:0]),
                .en_we    (sel_v[p] && wr_v[p] && (word_v[p] == WORD_W'(ENABLE_WORD))),
                .en_val   (wdat_v[p][NUM_SEM-1:0]),
                .status_o (status_v[p]),
                .enable_o (enable_v[p]),
                .irq_o    (irq_v[p])
            );

            always_comb begin
                rd_val[p] = '0;
                if (int'(word_v[p]) < NUM_SEM)
                    rd_val[p][0] = |grant_v[p];
                else if (word_v[p] == WORD_W'(STATUS_WORD))
                    rd_val[p][NUM_SEM-1:0] = status_v[p];
                else if (word_v[p] == WORD_W'(ENABLE_WORD))
                    rd_val[p][NUM_SEM-1:0] = enable_v[p];
            end

            always_ff @(posedge clk) begin
                if (!rst_n)                      rdata_q[p] <= '0;
                else if (sel_v[p] && !wr_v[p])   rdata_q[p] <= rd_val[p];
                else                             rdata_q[p] <= '0;
            end
        end

        for (k = 0; k < NUM_SEM; k++) begin : g_sem
            sem_cell u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .claim0 (claim_v[0][k]),
                .claim1 (claim_v[1][k]),
                .rel0   (rel_v[0][k]),
                .rel1   (rel_v[1][k]),
                .grant0 (grant_v[0][k]),
                .grant1 (grant_v[1][k]),
                .freed0 (freed_v[0][k]),
                .freed1 (freed_v[1][k])
            );
        end
    endgenerate

    assign rdata0  = rdata_q[0];
    assign rdata1  = rdata_q[1];
    assign intreq0 = irq_v[0];
    assign intreq1 = irq_v[1];
endmodule

// File: rtl/sem_irq_chk.sv
module sem_irq_chk
    import sem_irq_pkg::*;
#(
    parameter int NUM_SEM = 3,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel0,
    input logic              wr0,
    input logic [ADDR_W-1:0] addr0,
    input logic              sel1,
    input logic              wr1,
    input logic [ADDR_W-1:0] addr1,
    input logic [DATA_W-1:0] rdata0,
    input logic [DATA_W-1:0] rdata1,
    input logic              intreq0,
    input logic              intreq1
);
    logic sem_rd0, sem_rd1, ctl_wr0, ctl_wr1;
    assign sem_rd0 = sel0 && !wr0 && (int'(addr0[ADDR_W-1:2]) < NUM_SEM);
    assign sem_rd1 = sel1 && !wr1 && (int'(addr1[ADDR_W-1:2]) < NUM_SEM);
    assign ctl_wr0 = sel0 && wr0 && (int'(addr0[ADDR_W-1:2]) >= STATUS_WORD);
    assign ctl_wr1 = sel1 && wr1 && (int'(addr1[ADDR_W-1:2]) >= STATUS_WORD);

    p_claim_bit0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sem_rd0 |=> (rdata0[DATA_W-1:1] == '0));
    p_claim_bit1_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sem_rd1 |=> (rdata1[DATA_W-1:1] == '0));
    p_one_winner_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sem_rd0 && sem_rd1 && addr0 == addr1) |=> !(rdata0[0] && rdata1[0]));
    p_irq0_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (intreq0 && !ctl_wr0) |=> intreq0);
    p_irq1_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (intreq1 && !ctl_wr1) |=> intreq1);
    p_irq1_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(intreq1) |-> ($past(sel0) || $past(ctl_wr1)));
    p_irq0_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(intreq0) |-> ($past(sel1) || $past(ctl_wr0)));
endmodule

bind sem_irq_ctl sem_irq_chk #(
    .NUM_SEM(NUM_SEM), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .sel0(sel0), .wr0(wr0), .addr0(addr0),
    .sel1(sel1), .wr1(wr1), .addr1(addr1),
    .rdata0(rdata0), .rdata1(rdata1),
    .intreq0(intreq0), .intreq1(intreq1)
);

// File: tb/sem_irq_ctl_test.sv
`timescale 1ns/1ps
module sem_irq_ctl_test;
    localparam logic [4:0] A_SEM0 = 5'h00, A_SEM1 = 5'h04, A_SEM2 = 5'h08;
    localparam logic [4:0] A_STAT = 5'h10, A_EN = 5'h14;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        sel0 = 0, wr0 = 0, sel1 = 0, wr1 = 0;
    logic [4:0]  addr0 = '0, addr1 = '0;
    logic [31:0] wdata0 = '0, wdata1 = '0;
    logic [31:0] rdata0, rdata1;
    logic        intreq0, intreq1;
    int total = 0, bad = 0;

    always #5 clk = ~clk;

    sem_irq_ctl uut (
        .clk(clk), .rst_n(rst_n),
        .sel0(sel0), .wr0(wr0), .addr0(addr0), .wdata0(wdata0), .rdata0(rdata0),
        .sel1(sel1), .wr1(wr1), .addr1(addr1), .wdata1(wdata1), .rdata1(rdata1),
        .intreq0(intreq0), .intreq1(intreq1)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic acc(input int p, input logic w, input logic [4:0] a,
                       input logic [31:0] d, output logic [31:0] r);
        @(negedge clk);
        if (p == 0) begin sel0 = 1; wr0 = w; addr0 = a; wdata0 = d; end
        else        begin sel1 = 1; wr1 = w; addr1 = a; wdata1 = d; end
        @(posedge clk); #1;
        r = (p == 0) ? rdata0 : rdata1;
        sel0 = 0; sel1 = 0; wr0 = 0; wr1 = 0;
    endtask

    task automatic t_reset();
        logic [31:0] r;
        chk("R1 rdata0", rdata0, 0);
        chk("R1 intreq0", {31'b0, intreq0}, 0);
        chk("R1 intreq1", {31'b0, intreq1}, 0);
        acc(0, 0, A_STAT, 0, r); chk("R1 status0", r, 0);
        acc(1, 0, A_EN, 0, r);   chk("R1 enable1", r, 0);
    endtask

    task automatic t_claim();
        logic [31:0] r;
        acc(0, 0, A_SEM0, 0, r); chk("R2 p0 claims free sem0", r, 1);
        acc(1, 0, A_SEM0, 0, r); chk("R2 p1 claim of held sem0", r, 0);
        acc(0, 0, A_SEM0, 0, r); chk("R2 owner re-read of sem0", r, 0);
        acc(1, 0, A_STAT, 0, r); chk("R5 status1 after p0 claim", r, 1);
        acc(0, 0, A_STAT, 0, r); chk("R5 status0 after failed claims", r, 0);
        chk("R6 intreq1 masked", {31'b0, intreq1}, 0);
    endtask

    task automatic t_nonowner();
        logic [31:0] r;
        acc(1, 1, A_SEM0, 0, r);
        acc(0, 1, A_SEM0, 1, r);
        acc(1, 0, A_SEM0, 0, r); chk("R3 sem0 still held", r, 0);
        acc(0, 0, A_STAT, 0, r); chk("R3 ignored writes raise nothing", r, 0);
    endtask

    task automatic t_irq_w1c();
        logic [31:0] r;
        acc(1, 1, A_EN, 32'h7, r); chk("R6 intreq1 on enable", {31'b0, intreq1}, 1);
        acc(1, 0, A_EN, 0, r);     chk("R8 enable1 readback", r, 7);
        acc(1, 1, A_STAT, 0, r);
        acc(1, 0, A_STAT, 0, r);   chk("R7 zero write keeps status", r, 1);
        acc(1, 1, A_STAT, 1, r);   chk("R7 w1c drops intreq1", {31'b0, intreq1}, 0);
        acc(0, 1, A_SEM0, 0, r);   chk("R5 release by owner raises intreq1", {31'b0, intreq1}, 1);
        acc(1, 0, A_SEM0, 0, r);   chk("R3 p1 claims released sem0", r, 1);
        chk("R6 intreq0 masked", {31'b0, intreq0}, 0);
        acc(0, 0, A_STAT, 0, r);   chk("R5 status0 after p1 claim", r, 1);
        acc(0, 1, A_EN, 1, r);     chk("R6 intreq0 on enable", {31'b0, intreq0}, 1);
        acc(0, 1, A_STAT, 1, r);   chk("R7 w1c drops intreq0", {31'b0, intreq0}, 0);
        acc(1, 1, A_STAT, 7, r);
    endtask

    task automatic t_race();
        logic [31:0] r;
        @(negedge clk);
        sel0 = 1; wr0 = 0; addr0 = A_SEM1;
        sel1 = 1; wr1 = 0; addr1 = A_SEM1;
        @(posedge clk); #1;
        chk("R4 port0 wins race", rdata0, 1);
        chk("R4 port1 loses race", rdata1, 0);
        sel0 = 0; sel1 = 0;
        chk("R5 intreq1 after race claim", {31'b0, intreq1}, 1);
        acc(1, 0, A_STAT, 0, r); chk("R5 status1 bit1", r, 2);
        acc(1, 0, A_SEM2, 0, r); chk("R2 p1 claims sem2", r, 1);
        chk("R6 sem2 bit not enabled for port0", {31'b0, intreq0}, 0);
        acc(0, 0, A_STAT, 0, r); chk("R5 status0 bit2", r, 4);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_claim();
        t_nonowner();
        t_irq_w1c();
        t_race();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule